// File: doc/BRIEF.md
# Two-Lane Pipelined Polyphase FIR Filter

This block is a fixed-coefficient FIR filter that accepts a pair of consecutive 8-bit two's-complement samples on every clock and returns the matching pair of 16-bit results on every clock. Internally the tap set is split into an even-indexed and an odd-indexed sub-filter. Each output lane is formed from both input lanes through these two sub-filters, so the throughput is two samples per clock without a faster clock.

The critical path is kept short because no stage holds a whole multiply followed by an add. Each product is formed in two registered steps from two half-width partial products. The products of each lane are then summed in a registered binary tree with one level per stage. A valid flag travels with the data. Clocks with the valid input low neither advance the sample history nor produce an output pair.

Top module: `fir2p_top`

## Requirements
- R1: Every clock with `in_valid` high accepts one pair. `smp_early` holds sample x(2k) and `smp_late` holds the next sample x(2k+1). Exactly one output pair is produced for each accepted pair, in the same order.
- R2: `y_early` equals y(2k) and `y_late` equals y(2k+1), where y(n) = sum over k of h(k)·x(n−k). Samples before the first accepted sample count as zero. h(k) is the signed byte at bits [8k+7:8k] of `COEFS`, which defaults to h = 1, −2, 3, 127, −128, 5, −7, 11 for `NTAPS` = 8 (NTAPS must be even).
- R3: Sums wrap modulo 2^16 and are neither saturated nor rounded.
- R4: Inputs and coefficients are signed 8-bit values over their full range, including −128. Every 8x8 product is exact.
- R5: `out_valid` is `in_valid` delayed by exactly 3 + clog2(NTAPS) clocks, which is 6 for the default.
- R6: A clock with `in_valid` low does not shift the sample history. The filtered stream is therefore the sequence of accepted samples only, and the output data hold steady when such a cycle reaches the output.
- R7: A synchronous active-high `rst` clears the history and the pipeline. While reset is applied and for the first 6 clocks after it, `out_valid`, `y_early` and `y_late` are zero, and samples accepted before the reset add nothing to later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair present |
| smp_early | input | 8 | Earlier sample of the pair, x(2k) |
| smp_late | input | 8 | Later sample of the pair, x(2k+1) |
| out_valid | output | 1 | Output pair present |
| y_early | output | 16 | Result y(2k) |
| y_late | output | 16 | Result y(2k+1) |

## Verification
Single impulses are applied in each lane. If the lanes were swapped, or if the one-block delay on the odd sub-filter were misplaced, the response would land in the wrong lane or be shifted by one sample. A near-exhaustive sweep of one lane against a set of values in the other drives −128 into the −128 and 127 taps. This catches a multiplier that sign-extends its low partial product and an adder tree that saturates instead of wrapping. Bursts with idle gaps show whether the history shifts on invalid clocks, which would mix a stale sample into the next result. A reset in mid-stream, followed by an impulse, shows whether earlier samples leak into later outputs.

// File: rtl/fir2p_pkg.sv
package fir2p_pkg;

    localparam int SMP_W = 8;
    localparam int ACC_W = 16;
    localparam int SPLIT = SMP_W / 2;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    // one incoming block: two consecutive samples
    typedef struct packed {
        smp_t early;
        smp_t late;
    } pair_t;

    // partial products of one multiply, before merging
    typedef struct packed {
        acc_t hi_part;
        acc_t lo_part;
    } pp_pair_t;

    function automatic int tree_levels(input int n);
        return (n <= 1) ? 0 : $clog2(n);
    endfunction

    // history register + two multiplier stages + one stage per tree level
    function automatic int pipe_latency(input int ntaps);
        return 3 + tree_levels(ntaps);
    endfunction

    function automatic acc_t merge_parts(input pp_pair_t p);
        return (p.hi_part <<< SPLIT) + p.lo_part;
    endfunction

endpackage

// File: rtl/fir2p_mul.sv
module fir2p_mul
    import fir2p_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  smp_t a,
    input  smp_t b,
    output acc_t prod
);

    pp_pair_t pp_q;
    acc_t     a_ext;
    acc_t     lo_ext;
    acc_t     hi_ext;

    always_comb begin
        a_ext  = acc_t'(a);
        lo_ext = acc_t'({1'b0, b[SPLIT-1:0]});
        hi_ext = acc_t'($signed(b[SMP_W-1:SPLIT]));
    end

    // stage 1: two narrow partial products
    always_ff @(posedge clk) begin
        if (rst) begin
            pp_q <= '0;
        end else begin
            pp_q.lo_part <= a_ext * lo_ext;
            pp_q.hi_part <= a_ext * hi_ext;
        end
    end

    // stage 2: shift and merge
    always_ff @(posedge clk) begin
        if (rst) begin
            prod <= '0;
        end else begin
            prod <= merge_parts(pp_q);
        end
    end

endmodule

// File: rtl/fir2p_sum.sv
module fir2p_sum
    import fir2p_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  acc_t terms [N],
    output acc_t total
);

    localparam int LEVELS = tree_levels(N);
    localparam int WIDTH  = 1 << LEVELS;
    localparam int NODES  = 2 * WIDTH - 1;

    // heap order: node 0 is the root, leaves start at WIDTH-1
    acc_t node [NODES];

    genvar j;
    generate
        for (j = 0; j < WIDTH; j++) begin : g_leaf
            if (j < N) begin : g_used
                assign node[WIDTH-1+j] = terms[j];
            end else begin : g_pad
                assign node[WIDTH-1+j] = '0;
            end
        end
        for (j = 0; j < WIDTH - 1; j++) begin : g_node
            always_ff @(posedge clk) begin
                if (rst) begin
                    node[j] <= '0;
                end else begin
                    node[j] <= node[2*j+1] + node[2*j+2];
                end
            end
        end
    endgenerate

    assign total = node[0];

endmodule

// File: rtl/fir2p_top.sv
module fir2p_top
    import fir2p_pkg::*;
#(
    parameter int                    NTAPS = 8,
    parameter logic [NTAPS*8-1:0]    COEFS = 64'h0BF9_0580_7F03_FE01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  smp_early,
    input  logic [7:0]  smp_late,
    output logic        out_valid,
    output logic [15:0] y_early,
    output logic [15:0] y_late
);

    localparam int HALF = NTAPS / 2;
    localparam int LAT  = pipe_latency(NTAPS);

    pair_t in_pair;
    smp_t  hist_e [HALF];
    smp_t  hist_l [HALF+1];
    acc_t  prod_e [NTAPS];
    acc_t  prod_l [NTAPS];
    acc_t  sum_e;
    acc_t  sum_l;
    logic [LAT-1:0] vpipe;

    always_comb begin
        in_pair.early = smp_t'(smp_early);
        in_pair.late  = smp_t'(smp_late);
    end

    // sample history, advanced only by accepted pairs
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HALF; i++) hist_e[i] <= '0;
            for (int i = 0; i <= HALF; i++) hist_l[i] <= '0;
        end else if (in_valid) begin
            hist_e[0] <= in_pair.early;
            hist_l[0] <= in_pair.late;
            for (int i = 1; i < HALF; i++) hist_e[i] <= hist_e[i-1];
            for (int i = 1; i <= HALF; i++) hist_l[i] <= hist_l[i-1];
        end
    end

    genvar i;
    generate
        for (i = 0; i < HALF; i++) begin : g_tap
            localparam smp_t C_EV = smp_t'(COEFS[(2*i)*SMP_W +: SMP_W]);
            localparam smp_t C_OD = smp_t'(COEFS[(2*i+1)*SMP_W +: SMP_W]);

            // early lane: even taps on early history, odd taps on late history one block back
            fir2p_mul u_e_ev (.clk(clk), .rst(rst), .a(hist_e[i]),   .b(C_EV), .prod(prod_e[2*i]));
            fir2p_mul u_e_od (.clk(clk), .rst(rst), .a(hist_l[i+1]), .b(C_OD), .prod(prod_e[2*i+1]));
            // late lane: even taps on late history, odd taps on early history
            fir2p_mul u_l_ev (.clk(clk), .rst(rst), .a(hist_l[i]),   .b(C_EV), .prod(prod_l[2*i]));
            fir2p_mul u_l_od (.clk(clk), .rst(rst), .a(hist_e[i]),   .b(C_OD), .prod(prod_l[2*i+1]));
        end
    endgenerate

    fir2p_sum #(.N(NTAPS)) u_sum_e (.clk(clk), .rst(rst), .terms(prod_e), .total(sum_e));
    fir2p_sum #(.N(NTAPS)) u_sum_l (.clk(clk), .rst(rst), .terms(prod_l), .total(sum_l));

    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe <= '0;
        end else begin
            vpipe <= {vpipe[LAT-2:0], in_valid};
        end
    end

    assign out_valid = vpipe[LAT-1];
    assign y_early   = sum_e;
    assign y_late    = sum_l;

endmodule

// File: rtl/fir2p_chk.sv
module fir2p_chk
    import fir2p_pkg::*;
#(
    parameter int NTAPS = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        out_valid,
    input logic [15:0] y_early,
    input logic [15:0] y_late
);

    localparam int LAT = pipe_latency(NTAPS);

    int since;

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= 0;
        end else if (since < LAT + 2) begin
            since <= since + 1;
        end
    end

    // R5
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (since >= LAT) |-> (out_valid == $past(in_valid, LAT)));

    // R5
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (since > LAT && $rose(out_valid)) |-> ($past(in_valid, LAT) && !$past(in_valid, LAT + 1)));

    // R7
    reset_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (since < LAT) |-> (!out_valid && y_early == 16'd0 && y_late == 16'd0));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (since > LAT && !$past(in_valid, LAT)) |-> ($stable(y_early) && $stable(y_late)));

endmodule

bind fir2p_top fir2p_chk #(.NTAPS(NTAPS)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .y_early(y_early), .y_late(y_late)
);

// File: tb/sim_fir2p_top.sv
module sim_fir2p_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  smp_early = '0;
    logic [7:0]  smp_late = '0;
    logic        out_valid;
    logic [15:0] y_early;
    logic [15:0] y_late;

    fir2p_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .smp_early(smp_early), .smp_late(smp_late),
        .out_valid(out_valid), .y_early(y_early), .y_late(y_late)
    );

    always #4 clk = ~clk;

    int h [8] = '{1, -2, 3, 127, -128, 5, -7, 11};
    int xs [16384];
    int ns = 0;
    int nout = 0;
    int base = 0;
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    string tag = "R2";

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic int ref_y(input int n);
        int s = 0;
        for (int k = 0; k < 8; k++) begin
            if (n - k >= base) s += h[k] * xs[n-k];
        end
        return s & 16'hFFFF;
    endfunction

    task automatic push(input int a, input int b);
        @(negedge clk);
        smp_early = 8'(a);
        smp_late  = 8'(b);
        in_valid  = 1'b1;
        xs[ns]    = int'($signed(8'(a)));
        xs[ns+1]  = int'($signed(8'(b)));
        ns += 2;
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // output monitor: compare each valid pair against the scalar convolution
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            chk({tag, " early"}, int'(y_early), ref_y(nout));
            chk({tag, " late"},  int'(y_late),  ref_y(nout + 1));
            nout += 2;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        int lat;
        // R7: outputs cleared while in reset
        repeat (3) @(negedge clk);
        chk("R7 reset valid", int'(out_valid), 0);
        chk("R7 reset early", int'(y_early), 0);
        chk("R7 reset late", int'(y_late), 0);
        @(negedge clk);
        rst = 1'b0;
        idle(3);

        // R5: latency of a single pair; R2 impulse in early lane
        tag = "R2";
        push(1, 0);
        lat = 0;
        for (int c = 1; c <= 12; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (out_valid && lat == 0) lat = c;
        end
        chk("R5 latency", lat, 6);
        for (int c = 0; c < 5; c++) push(0, 0);
        idle(10);

        // R2: impulse in late lane
        push(0, 1);
        for (int c = 0; c < 5; c++) push(0, 0);
        idle(10);

        // R4 / R3: extreme operands
        tag = "R4";
        for (int c = 0; c < 8; c++) push(-128, -128);
        for (int c = 0; c < 8; c++) push(127, 127);
        for (int c = 0; c < 8; c++) push(-128, 127);
        for (int c = 0; c < 8; c++) push(127, -128);
        tag = "R3";
        for (int c = 0; c < 8; c++) push((c % 2) ? 127 : -128, (c % 2) ? -128 : 127);
        idle(10);

        // R6: bursts separated by idle clocks
        tag = "R6";
        for (int c = 0; c < 60; c++) begin
            push(c * 29 - 100, 77 - c * 13);
            if (c % 3 == 1) idle(1);
            if (c % 7 == 3) idle(2);
        end
        idle(10);

        // R2 / R4: sweep every early value against sixteen late values
        tag = "R4 sweep";
        for (int b = 0; b < 16; b++) begin
            for (int a = 0; a < 256; a++) begin
                push(a, b * 17 - 128);
            end
        end
        idle(10);

        // R7: reset mid-stream, then impulse must show no residue
        tag = "R7";
        for (int c = 0; c < 6; c++) push(100 - c, -90 + c);
        idle(10);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 mid reset valid", int'(out_valid), 0);
        chk("R7 mid reset early", int'(y_early), 0);
        rst = 1'b0;
        base = ns;
        push(3, 0);
        for (int c = 0; c < 5; c++) push(0, 0);
        idle(12);

        // R1: one output pair per accepted pair
        chk("R1 pair count", nout, ns);
        finish_run();
    end

endmodule